// File: doc/BRIEF.md
# Single-Control Data Crossing Synchronizer

This block carries a multi-bit word from a source clock domain into an unrelated destination clock domain. The source launches the word and a one-bit ready level from its own registers. Only the ready level passes through a chain of destination-clocked flip-flops. The last stage of that chain drives a recirculating multiplexer in front of the destination data register. While ready is seen high, the register reloads the launched word. While it is low, the register feeds its own output back and keeps its value.

The scheme is safe only if the source follows two rules. First, the ready level must stay put long enough for the chain to see it. Second, the word must not move while the destination sees ready. The block watches both rules in the destination domain and reports any breach on sticky error outputs. The word bits are never synchronized one by one. The first chain stage feeds only the second stage, and only the last stage fans out.

Top module: `msync_top`

## Requirements
- R1: After both resets, `dst_rdy_o`, `dst_data_o`, `err_data_o` and `err_ctrl_o` are all 0.
- R2: `src_rdy_i` and `src_data_i` are captured on a rising `src_clk_i` edge.
- R3: `dst_rdy_o` takes the captured ready value exactly DEPTH rising `dst_clk_i` edges after the capturing source edge, for both rising and falling ready. It is unchanged after DEPTH-1 such edges.
- R4: `dst_data_o` equals the captured word one `dst_clk_i` edge after `dst_rdy_o` goes high, and not before.
- R5: While `dst_rdy_o` is 0, `dst_data_o` holds its value whatever `src_data_i` does.
- R6: `err_data_o` goes to 1 if the captured word changes between two consecutive destination edges at both of which `dst_rdy_o` was 1.
- R7: `err_ctrl_o` goes to 1 if `dst_rdy_o` changes again fewer than DEPTH+1 destination edges after its previous change. Equivalently, this happens if the source holds ready for less than DEPTH+1 destination periods. A ready level held for many destination periods never sets it.
- R8: Both error outputs stay at 1 once set, and are cleared only by `dst_rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source clock |
| src_rst_ni | input | 1 | Source asynchronous reset, active low |
| src_data_i | input | WIDTH | Word to transfer |
| src_rdy_i | input | 1 | Source ready level |
| dst_clk_i | input | 1 | Destination clock |
| dst_rst_ni | input | 1 | Destination asynchronous reset, active low |
| dst_data_o | output | WIDTH | Destination data register |
| dst_rdy_o | output | 1 | Synchronized ready level |
| err_data_o | output | 1 | Sticky flag: word moved while ready was seen |
| err_ctrl_o | output | 1 | Sticky flag: ready level held too briefly |

## Verification
The clocks are chosen so that no source edge meets a destination edge, which keeps every latency exact. After the source edge that captures ready, the bench counts DEPTH-1 destination edges and confirms `dst_rdy_o` has not moved yet. One edge later it confirms the new level, and one edge after that it confirms the loaded word. Every sample falls 1 ns after a destination edge. The error flags register one edge after the offending sample, so the bench checks them only after several destination edges have passed. It checks them again later to confirm they stay set.

// File: rtl/msync_pkg.sv
package msync_pkg;
  localparam int unsigned MIN_DEPTH = 2;

  // counter width able to hold 0..depth+1
  function automatic int unsigned gap_w(int unsigned depth);
    return $clog2(depth + 2);
  endfunction
endpackage

// File: rtl/msync_chain.sv
module msync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import msync_pkg::*;

  if (DEPTH < MIN_DEPTH) begin : g_bad_depth
    $error("msync_chain: DEPTH below minimum");
  end

  logic [DEPTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  // only the last stage leaves the chain
  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/msync_capture.sv
module msync_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             err_o
);
  logic [WIDTH-1:0] data_q, data_nxt;
  logic             load_d;
  logic             err_q;

  // recirculating mux
  always_comb data_nxt = load_i ? data_i : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      load_d <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      data_q <= data_nxt;
      load_d <= load_i;
      if (load_i && load_d && (data_i != data_q)) err_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign err_o  = err_q;
endmodule

// File: rtl/msync_toggle_mon.sv
module msync_toggle_mon #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic err_o
);
  import msync_pkg::*;

  localparam int unsigned   GW     = gap_w(DEPTH);
  localparam logic [GW-1:0] GAP_OK = GW'(DEPTH + 1);

  logic [GW-1:0] gap_q;
  logic          prev_q;
  logic          err_q;
  logic          chg;

  assign chg = sync_i ^ prev_q;

  // gap_q = destination edges since last change, saturating at DEPTH+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= GAP_OK;
      prev_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (chg) begin
        gap_q <= GW'(1);
        if (gap_q < GAP_OK) err_q <= 1'b1;
      end else if (gap_q != GAP_OK) begin
        gap_q <= gap_q + GW'(1);
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/msync_top.sv
module msync_top #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic             src_clk_i,
  input  logic             src_rst_ni,
  input  logic [WIDTH-1:0] src_data_i,
  input  logic             src_rdy_i,
  input  logic             dst_clk_i,
  input  logic             dst_rst_ni,
  output logic [WIDTH-1:0] dst_data_o,
  output logic             dst_rdy_o,
  output logic             err_data_o,
  output logic             err_ctrl_o
);
  logic [WIDTH-1:0] src_data_q;
  logic             src_rdy_q;
  logic             rdy_sync;

  // launch registers: nothing combinational reaches the other domain
  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni) begin
      src_data_q <= '0;
      src_rdy_q  <= 1'b0;
    end else begin
      src_data_q <= src_data_i;
      src_rdy_q  <= src_rdy_i;
    end
  end

  msync_chain #(.DEPTH(DEPTH)) u_chain (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .d_i    (src_rdy_q),
    .q_o    (rdy_sync)
  );

  msync_capture #(.WIDTH(WIDTH)) u_capture (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .load_i (rdy_sync),
    .data_i (src_data_q),
    .data_o (dst_data_o),
    .err_o  (err_data_o)
  );

  msync_toggle_mon #(.DEPTH(DEPTH)) u_mon (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .sync_i (rdy_sync),
    .err_o  (err_ctrl_o)
  );

  assign dst_rdy_o = rdy_sync;
endmodule

// File: rtl/msync_checker.sv
module msync_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic             dst_clk_i,
  input logic             dst_rst_ni,
  input logic [WIDTH-1:0] src_data_q,
  input logic [WIDTH-1:0] dst_data_o,
  input logic             dst_rdy_o,
  input logic             err_data_o,
  input logic             err_ctrl_o
);
  a_r4_load_on_ready: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    dst_rdy_o |=> dst_data_o == $past(src_data_q));

  a_r5_hold_when_idle: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    !dst_rdy_o |=> $stable(dst_data_o));

  a_r6_flag_on_move: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    (dst_rdy_o && $past(dst_rdy_o) && (src_data_q != $past(src_data_q))) |=> err_data_o);

  a_r8_data_sticky: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    err_data_o |=> err_data_o);

  a_r8_ctrl_sticky: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    err_ctrl_o |=> err_ctrl_o);
endmodule

bind msync_top msync_checker #(.WIDTH(WIDTH)) u_chk (
  .dst_clk_i  (dst_clk_i),
  .dst_rst_ni (dst_rst_ni),
  .src_data_q (src_data_q),
  .dst_data_o (dst_data_o),
  .dst_rdy_o  (dst_rdy_o),
  .err_data_o (err_data_o),
  .err_ctrl_o (err_ctrl_o)
);

// File: tb/msync_top_tb.sv
`timescale 1ns/1ps
module msync_top_tb;
  localparam int unsigned W = 16;
  localparam int unsigned M = 3;

  logic         src_clk = 1'b0, dst_clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_rdy = 1'b0;
  logic [W-1:0] dst_data;
  logic         dst_rdy, err_data, err_ctrl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2   dst_clk = ~dst_clk;   // 250 MHz, edges at 2,6,10...
  always #3.5 src_clk = ~src_clk;   // edges at 3.5,10.5...: never coincide

  msync_top #(.WIDTH(W), .DEPTH(M)) u_dut (
    .src_clk_i (src_clk), .src_rst_ni (rst_n), .src_data_i (src_data), .src_rdy_i (src_rdy),
    .dst_clk_i (dst_clk), .dst_rst_ni (rst_n), .dst_data_o (dst_data), .dst_rdy_o (dst_rdy),
    .err_data_o (err_data), .err_ctrl_o (err_ctrl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dst_wait(input int n);
    repeat (n) @(posedge dst_clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_rdy = 1'b0; src_data = '0;
    dst_wait(3);
    chk(dst_rdy == 0 && dst_data == 0, "R1 outputs", {dst_rdy, dst_data}, 0);
    chk(err_data == 0 && err_ctrl == 0, "R1 flags", {err_data, err_ctrl}, 0);
    @(negedge dst_clk); rst_n = 1'b1;
    dst_wait(2);
  endtask

  task automatic t_rise(input logic [W-1:0] word);
    logic [W-1:0] old = dst_data;
    @(negedge src_clk); src_data = word; src_rdy = 1'b1;
    @(posedge src_clk);
    dst_wait(M - 1);
    chk(dst_rdy == 0, "R3 rise early", dst_rdy, 0);
    dst_wait(1);
    chk(dst_rdy == 1, "R3 rise", dst_rdy, 1);
    chk(dst_data == old, "R4 not yet", dst_data, old);
    dst_wait(1);
    chk(dst_data == word, "R2 R4 load", dst_data, word);
  endtask

  task automatic t_fall();
    @(negedge src_clk); src_rdy = 1'b0;
    @(posedge src_clk);
    dst_wait(M - 1);
    chk(dst_rdy == 1, "R3 fall early", dst_rdy, 1);
    dst_wait(1);
    chk(dst_rdy == 0, "R3 fall", dst_rdy, 0);
    chk(err_data == 0, "R6 clean", err_data, 0);
    chk(err_ctrl == 0, "R7 clean", err_ctrl, 0);
  endtask

  task automatic t_hold(input logic [W-1:0] junk);
    logic [W-1:0] kept = dst_data;
    @(negedge src_clk); src_data = junk;
    dst_wait(8);
    chk(dst_data == kept, "R5 hold", dst_data, kept);
    chk(err_data == 0, "R5 no flag", err_data, 0);
  endtask

  task automatic t_data_violation();
    t_rise(16'h1234);
    @(negedge src_clk); src_data = 16'h4321;
    @(posedge src_clk);
    dst_wait(3);
    chk(err_data == 1, "R6 flag", err_data, 1);
    chk(err_ctrl == 0, "R7 unaffected", err_ctrl, 0);
    @(negedge src_clk); src_data = 16'h1234;
    dst_wait(10);
    chk(err_data == 1, "R8 data sticky", err_data, 1);
    do_reset();
    chk(err_data == 0, "R8 data cleared", err_data, 0);
  endtask

  task automatic t_ctrl_violation();
    @(negedge src_clk); src_rdy = 1'b1;
    @(negedge src_clk); src_rdy = 1'b0;
    dst_wait(M + 6);
    chk(err_ctrl == 1, "R7 flag", err_ctrl, 1);
    dst_wait(10);
    chk(err_ctrl == 1, "R8 ctrl sticky", err_ctrl, 1);
    do_reset();
    chk(err_ctrl == 0, "R8 ctrl cleared", err_ctrl, 0);
  endtask

  initial begin
    do_reset();
    t_rise(16'hA5C3);
    t_fall();
    t_hold(16'hFFFF);
    t_rise(16'h0001);
    t_fall();
    t_hold(16'h0000);
    t_rise(16'h8000);
    t_fall();
    t_data_violation();
    t_ctrl_violation();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule